// File: doc/BRIEF.md
# Two-Byte Register Target on a Two-Wire Serial Bus

This block is an I2C target that keeps a small file of 16-bit registers. A controller chooses a register with a command byte and moves its contents as two bytes, upper byte first, MSB first within each byte. SCL and SDA pass through synchronizers inside the system clock domain. SDA is driven only through an open-drain enable that pulls the line low. Start, repeated start and stop are found as SDA edges while SCL is high.

The target answers to its own 7-bit address and to a broadcast address. The broadcast address is accepted for writes only, so one transfer can update many targets. There are two ways to read. A combined read sends a command byte and then a repeated start into a read. A direct read sends a read address with no command byte in the transfer, and it returns the register written most recently. Command codes that map to no register are still acknowledged: writes to them are dropped and reads from them return zero.

Top module: `i2c_regfile_target`

## Requirements
- R1: After reset, sda_oe is 0. The registers hold these code/value pairs: D0h=000Ch, D1h=01F0h, D2h=0000h, D3h=0008h, 21h=0000h, 25h=0000h, 26h=0000h, 01h=0000h, 78h=0000h, 98h=2200h.
- R2: An address byte whose upper seven bits equal DEV_ADDR is acknowledged (SDA low in the ninth clock) for either R/W value (bit 0: 0 write, 1 read). Any other address, except the case in R3, is not acknowledged.
- R3: The broadcast address BCAST_ADDR with R/W=0 is acknowledged and the write proceeds. With R/W=1 it is not acknowledged, and SDA stays released for the rest of the transfer.
- R4: A write is address(R/W=0), command, upper byte, lower byte, and every byte is acknowledged. The register changes only once the lower byte is taken. A stop after the upper byte leaves the register unchanged.
- R5: A combined read (address W, command, repeated start, address R) returns the upper byte and then the lower byte of the selected register, MSB first.
- R6: The lower byte is sent only if the controller acknowledges the upper byte. After a NACK the target releases SDA and drives no more data.
- R7: A read address with no command byte earlier in the transfer returns the register most recently written. That pointer is set to the command code of each completed write, including unmapped codes, and it resets to D0h.
- R8: A command code that maps to no register is acknowledged. A write to it changes no register, and a read from it returns 0000h.
- R9: sda_oe changes only while SCL is low. A start or stop releases SDA.
- R10: A stop returns the target to idle and clears the selected command. A read after a new start with no command byte is therefore a direct read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |

## Verification
The assertions assume that the controller moves SDA only while SCL is low, except when it makes a start or a stop. They also assume that each SCL phase lasts longer than the synchronizer latency plus two clocks, so that every edge is seen once and in order. The bench holds each SCL quarter-bit for ten system clocks and changes its own SDA only at the start of a low phase or inside the start and stop sequences. It never drives SDA against a target that is holding the line low.

// File: rtl/i2c_rf_pkg.sv
// Package: shared state types and the register file contents of the
// two-byte register target. Assumes a fixed list of mapped command codes.
package i2c_rf_pkg;

    localparam int NREG = 10;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_RXEND, ST_ACK, ST_TX, ST_MACK
    } st_e;

    typedef enum logic [1:0] {
        RL_ADDR, RL_CMD, RL_DHI, RL_DLO
    } role_e;

    // Command code of register slot i.
    function automatic logic [7:0] reg_code(input int i);
        case (i)
            0: return 8'hD0;
            1: return 8'hD1;
            2: return 8'hD2;
            3: return 8'hD3;
            4: return 8'h21;
            5: return 8'h25;
            6: return 8'h26;
            7: return 8'h01;
            8: return 8'h78;
            default: return 8'h98;
        endcase
    endfunction

    // Reset value of register slot i.
    function automatic logic [15:0] reg_rst(input int i);
        case (i)
            0: return 16'h000C;
            1: return 16'h01F0;
            3: return 16'h0008;
            9: return 16'h2200;
            default: return 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/i2c_bus_sync.sv
// Bus synchronizer: brings SCL and SDA into the clk domain and finds
// SCL edges plus start/stop conditions. Assumes bus phases last longer
// than STAGES+1 clocks. Idle bus level is high.
module i2c_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_d, sda_d;

    // Purpose: metastability chains plus one delayed copy for edge finding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    // Purpose: edge and bus-condition decode.
    always_comb begin
        scl_s    = scl_pipe[STAGES-1];
        sda_s    = sda_pipe[STAGES-1];
        scl_rise = scl_s & ~scl_d;
        scl_fall = ~scl_s & scl_d;
        start_ev = scl_s & scl_d & sda_d & ~sda_s;
        stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/i2c_rf_store.sv
// Register store: one 16-bit register per mapped command code, with the
// reset values from the package. Unmapped codes are ignored on write and
// read as zero. Read is combinational.
module i2c_rf_store
    import i2c_rf_pkg::*;
#(
    parameter int N = NREG
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_code,
    input  logic [15:0] wr_data,
    input  logic [7:0]  rd_code,
    output logic [15:0] rd_data
);
    logic [N-1:0][15:0] regs;
    logic               wr_hit;

    for (genvar i = 0; i < N; i++) begin : g_reg
        // Purpose: hold one register, load on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= reg_rst(i);
            else if (wr_en && wr_code == reg_code(i))
                regs[i] <= wr_data;
        end
    end

    // Purpose: code-to-register read mux, zero on no match.
    always_comb begin
        rd_data = '0;
        wr_hit  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (rd_code == reg_code(i)) rd_data = regs[i];
            if (wr_code == reg_code(i)) wr_hit = 1'b1;
        end
    end

    AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hit) |=> $stable(regs)); // R8
endmodule

// File: rtl/i2c_regfile_target.sv
// Two-byte register target: byte-level protocol engine for an I2C target
// with its own address and a write-only broadcast address, combined and
// direct reads, and open-drain SDA. Assumes no clock stretching is needed
// and that SCL phases outlast the synchronizer delay.
module i2c_regfile_target
    import i2c_rf_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h48,
    parameter logic [6:0] BCAST_ADDR  = 7'h47,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe
);
    localparam logic [7:0] PTR_RST = reg_code(0);

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    st_e         state;
    role_e       role;
    logic [2:0]  bitcnt;
    logic [7:0]  shreg, cmd_q, last_ptr, hi_q;
    logic        rw, cmd_seen, tx_lo, mack;
    logic        wr_en;
    logic [15:0] wr_data, rd_data;
    logic [7:0]  rd_code;
    logic        addr_ok;

    i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
    );

    i2c_rf_store #(.N(NREG)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_code(last_ptr),
        .wr_data(wr_data), .rd_code(rd_code), .rd_data(rd_data)
    );

    // Purpose: read source select and address match.
    always_comb begin
        rd_code = cmd_seen ? cmd_q : last_ptr;
        addr_ok = (shreg[7:1] == DEV_ADDR) ||
                  (shreg[7:1] == BCAST_ADDR && !shreg[0]);
    end

    // Purpose: protocol state machine and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            role     <= RL_ADDR;
            bitcnt   <= '0;
            shreg    <= '0;
            cmd_q    <= '0;
            hi_q     <= '0;
            last_ptr <= PTR_RST;
            rw       <= 1'b0;
            cmd_seen <= 1'b0;
            tx_lo    <= 1'b0;
            mack     <= 1'b0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_ev) begin
                state  <= ST_RX;
                role   <= RL_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (stop_ev) begin
                state    <= ST_IDLE;
                sda_oe   <= 1'b0;
                cmd_seen <= 1'b0;
            end else begin
                case (state)
                    ST_RX: if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 3'd1;
                        if (bitcnt == 3'd7) state <= ST_RXEND;
                    end
                    ST_RXEND: if (scl_fall) begin
                        state  <= ST_ACK;
                        sda_oe <= 1'b1;
                        case (role)
                            RL_ADDR: begin
                                rw <= shreg[0];
                                if (!addr_ok) begin
                                    state  <= ST_IDLE;
                                    sda_oe <= 1'b0;
                                end
                            end
                            RL_CMD: begin
                                cmd_q    <= shreg;
                                cmd_seen <= 1'b1;
                            end
                            RL_DHI: begin
                                hi_q     <= shreg;
                                cmd_seen <= 1'b0;
                            end
                            default: begin
                                wr_en    <= 1'b1;
                                wr_data  <= {hi_q, shreg};
                                last_ptr <= cmd_q;
                            end
                        endcase
                    end
                    ST_ACK: if (scl_fall) begin
                        bitcnt <= '0;
                        if (role == RL_ADDR && rw) begin
                            shreg  <= rd_data[15:8];
                            sda_oe <= ~rd_data[15];
                            tx_lo  <= 1'b0;
                            state  <= ST_TX;
                        end else if (role == RL_DLO) begin
                            sda_oe <= 1'b0;
                            state  <= ST_IDLE;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_RX;
                            case (role)
                                RL_ADDR: role <= RL_CMD;
                                RL_CMD:  role <= RL_DHI;
                                default: role <= RL_DLO;
                            endcase
                        end
                    end
                    ST_TX: if (scl_fall) begin
                        if (bitcnt == 3'd7) begin
                            sda_oe <= 1'b0;
                            state  <= ST_MACK;
                        end else begin
                            shreg  <= {shreg[6:0], 1'b0};
                            sda_oe <= ~shreg[6];
                            bitcnt <= bitcnt + 3'd1;
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) mack <= ~sda_s;
                        if (scl_fall) begin
                            if (mack && !tx_lo) begin
                                shreg  <= rd_data[7:0];
                                sda_oe <= ~rd_data[7];
                                tx_lo  <= 1'b1;
                                bitcnt <= '0;
                                state  <= ST_TX;
                            end else begin
                                sda_oe   <= 1'b0;
                                cmd_seen <= 1'b0;
                                state    <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> (!$past(scl_s) || $past(start_ev) || $past(stop_ev))); // R9
    AST_RX_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RX) |-> !sda_oe); // R9
    AST_BCAST_READ_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RXEND && role == RL_ADDR && scl_fall && !start_ev && !stop_ev
         && shreg == {BCAST_ADDR, 1'b1}) |=> !sda_oe); // R3
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state == ST_IDLE && !sda_oe)); // R10
    AST_MACK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MACK) |-> !sda_oe); // R6
endmodule

// File: tb/sim_i2c_regfile_target.sv
// Bench: bit-level bus controller with a behavioural register model and a
// per-clock SDA timing monitor.
module sim_i2c_regfile_target;
    localparam logic [6:0] DEV = 7'h48;
    localparam logic [6:0] BC  = 7'h47;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    wire  sda_line = m_sda & ~sda_oe;

    int n_chk = 0, n_fail = 0, viol = 0;
    logic prev_oe = 1'b0;
    logic [15:0] mdl [256];
    logic [7:0]  last_w;

    always #10 clk = ~clk;

    i2c_regfile_target #(.DEV_ADDR(DEV), .BCAST_ADDR(BC)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe)
    );

    // Per-clock comparison: SDA drive may only change while SCL is low (R9).
    always @(negedge clk) begin
        if (rst_n && scl && (sda_oe !== prev_oe)) viol++;
        prev_oe = sda_oe;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; wt(Q); scl = 1'b1; wt(Q); m_sda = 1'b0; wt(Q); scl = 1'b0; wt(Q);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; wt(Q); scl = 1'b1; wt(Q); m_sda = 1'b1; wt(Q);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        m_sda = b; wt(Q); scl = 1'b1; wt(Q); s = sda_line; wt(Q); scl = 1'b0; wt(Q);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic rbyte(input logic ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(~ack, s);
    endtask

    task automatic wr_reg(input logic [6:0] a, input logic [7:0] code,
                          input logic [15:0] d, output logic ackall);
        logic a0, a1, a2, a3;
        bus_start;
        wbyte({a, 1'b0}, a0); wbyte(code, a1); wbyte(d[15:8], a2); wbyte(d[7:0], a3);
        bus_stop;
        ackall = a0 & a1 & a2 & a3;
        if (code == 8'hD0 || code == 8'hD1 || code == 8'hD2 || code == 8'hD3 ||
            code == 8'h21 || code == 8'h25 || code == 8'h26 || code == 8'h01 ||
            code == 8'h78 || code == 8'h98)
            mdl[code] = d;
        last_w = code;
    endtask

    task automatic rd_comb(input logic [7:0] code, output logic [15:0] d, output logic ackall);
        logic a0, a1, a2;
        bus_start;
        wbyte({DEV, 1'b0}, a0); wbyte(code, a1);
        bus_start;
        wbyte({DEV, 1'b1}, a2); rbyte(1'b1, d[15:8]); rbyte(1'b0, d[7:0]);
        bus_stop;
        ackall = a0 & a1 & a2;
    endtask

    task automatic rd_direct(output logic [15:0] d, output logic ack);
        bus_start;
        wbyte({DEV, 1'b1}, ack); rbyte(1'b1, d[15:8]); rbyte(1'b0, d[7:0]);
        bus_stop;
    endtask

    initial begin
        logic [15:0] d;
        logic ak;
        logic [7:0] b;
        for (int i = 0; i < 256; i++) mdl[i] = 16'h0000;
        mdl[8'hD0] = 16'h000C; mdl[8'hD1] = 16'h01F0; mdl[8'hD3] = 16'h0008; mdl[8'h98] = 16'h2200;
        last_w = 8'hD0;
        wt(5);
        chk("R1 sda_oe in reset", sda_oe, 0);
        rst_n = 1'b1;
        wt(5);

        rd_direct(d, ak);
        chk("R2 own read address acked", ak, 1);
        chk("R7 direct read after reset uses D0h", d, mdl[last_w]);

        rd_comb(8'hD1, d, ak); chk("R5 combined read acks", ak, 1); chk("R1 D1h reset", d, mdl[8'hD1]);
        rd_comb(8'h98, d, ak); chk("R1 98h reset", d, mdl[8'h98]);
        rd_comb(8'hD3, d, ak); chk("R1 D3h reset", d, mdl[8'hD3]);

        wr_reg(DEV, 8'h21, 16'hA5C3, ak); chk("R4 write bytes acked", ak, 1);
        rd_comb(8'h21, d, ak); chk("R5 readback 21h", d, mdl[8'h21]);
        wr_reg(DEV, 8'h25, 16'h1234, ak);
        rd_direct(d, ak); chk("R7 direct read last written", d, mdl[last_w]);

        wr_reg(BC, 8'h26, 16'h0BEE, ak); chk("R3 broadcast write acked", ak, 1);
        rd_comb(8'h26, d, ak); chk("R3 broadcast write landed", d, mdl[8'h26]);

        bus_start; wbyte({BC, 1'b1}, ak); rbyte(1'b0, b); bus_stop;
        chk("R3 broadcast read not acked", ak, 0);
        chk("R3 broadcast read SDA released", b, 8'hFF);

        bus_start; wbyte({7'h10, 1'b0}, ak); bus_stop;
        chk("R2 foreign address not acked", ak, 0);

        bus_start; wbyte({DEV, 1'b0}, ak); wbyte(8'h25, ak); wbyte(8'h77, ak); bus_stop;
        rd_comb(8'h25, d, ak); chk("R4 partial write leaves register", d, mdl[8'h25]);

        bus_start; wbyte({DEV, 1'b1}, ak); rbyte(1'b0, b);
        chk("R6 upper byte before NACK", b, mdl[last_w][15:8]);
        rbyte(1'b0, b); bus_stop;
        chk("R6 no lower byte after NACK", b, 8'hFF);

        wr_reg(DEV, 8'h55, 16'hABCD, ak); chk("R8 unmapped write acked", ak, 1);
        rd_comb(8'h55, d, ak); chk("R8 unmapped read zero", d, 0);
        rd_direct(d, ak); chk("R7 pointer follows unmapped code", d, 0);
        rd_comb(8'h21, d, ak); chk("R8 mapped register untouched", d, mdl[8'h21]);

        bus_start; wbyte({DEV, 1'b0}, ak); wbyte(8'hD1, ak); bus_stop;
        rd_direct(d, ak); chk("R10 stop clears command selection", d, mdl[last_w]);

        chk("R9 SDA changes only with SCL low", viol, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule